// File: doc/BRIEF.md
# Burst-Four Split-Port Memory Pipeline

This block is a memory with separate write-data and read-data paths that moves every access as a burst of four words. Each clock cycle, two active-low strobes and a burst address are sampled on the rising edge. Double-data-rate transfers are modelled as a pair of words per cycle: the `_rise` word stands for the first half of the cycle and the `_fall` word for the second half.

The write data for a write command comes in the two cycles that follow it. The read data leaves in the third and fourth cycles after the read command. A burst holds its bus for two cycles, so a second command of the same kind is refused in the cycle right after an accepted one. A read and a write can alternate on every cycle.

The read bus is never left undefined. In any cycle that carries no read data, it shows an idle value chosen by a termination setting: either driven to zero or released.

Top module: `burst4_sram`

## Requirements
- R1: `rd_n` and `wr_n` are active low and are sampled with `cmd_addr` on each rising edge. A low `rd_n` makes the cycle a read, and then `wr_n` is disregarded. Otherwise a low `wr_n` makes the cycle a write. Otherwise the cycle is a no-op.
- R2: For a write accepted at edge n, `d_rise`/`d_fall` sampled at edge n+1 become words 0/1 of the burst at that address, and those sampled at edge n+2 become words 2/3.
- R3: For a read accepted at edge n, `q_rise`/`q_fall` show words 0/1 with `q_oe`=1 from edge n+3, and words 2/3 with `q_oe`=1 from edge n+4.
- R4: In the cycle right after an accepted read, a low `rd_n` is not a read.
- R5: In the cycle right after an accepted write, a low `wr_n` is not a write, and the address of that cycle is left unchanged.
- R6: For a no-op or write at edge n, the bus from edge n+3 shows the idle value: `q_rise`=`q_fall`=0, with `q_oe` equal to `odt_en` (1 means driven low, 0 means released).
- R7: The idle value of R6 is not shown when the cycle before the no-op or write was an accepted read. That read's words 2/3 occupy the bus instead.
- R8: A read returns every write accepted before it, including a write in the cycle just before it. A write accepted in the cycle just after a read does not change that read's data.
- R9: `rst` is synchronous and active high. It forces `q_oe`=0 and `q_rise`=`q_fall`=0, and clears the pending commands so that the next three cycles show the idle value. Stored words are kept across reset.
- R10: Each address holds its own four-word burst. Writing one address leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_addr | input | ADDR_W | Burst address of the command |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| d_rise | input | DATA_W | Write word for the first half-cycle |
| d_fall | input | DATA_W | Write word for the second half-cycle |
| odt_en | input | 1 | Idle mode: 1 drives zero, 0 releases the bus |
| q_rise | output | DATA_W | Read word for the first half-cycle |
| q_fall | output | DATA_W | Read word for the second half-cycle |
| q_oe | output | 1 | Read bus driven when 1, released when 0 |

## Verification
The assertions assume that `rst` is high before the first edge. They also assume that `odt_en` is stable whenever an idle value is expected, because its value is taken at the edge that starts the idle cycle. The stimulus raises reset at the start of each phase and sets `odt_en` only while reset is high. The strobes are otherwise unconstrained: back-to-back reads, back-to-back writes and both strobes low together all occur, so the refusal rules are exercised rather than avoided.

// File: rtl/burst4_pkg.sv
package burst4_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    localparam int BURST       = 4;
    localparam int PER_CYCLE   = 2;
    localparam int HALVES      = BURST / PER_CYCLE;
    localparam int PIPE_STAGES = 4;

    // Read wins over write; a kind just accepted is refused for one cycle.
    function automatic op_e pick_op(input logic r_n, input logic w_n, input op_e last);
        if (!r_n && last != OP_RD) return OP_RD;
        if (!w_n && last != OP_WR) return OP_WR;
        return OP_NOP;
    endfunction

endpackage

// File: rtl/b4_cmd_pipe.sv
module b4_cmd_pipe
    import burst4_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              r_n,
    input  logic              w_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               now_op,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output op_e               s3_op,
    output op_e               s4_op
);
    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] a;
    } stage_t;

    stage_t st [PIPE_STAGES];

    assign now_op = pick_op(r_n, w_n, st[0].op);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_STAGES; i++) st[i] <= '{op: OP_NOP, a: '0};
        end else begin
            st[0] <= '{op: now_op, a: addr};
            for (int i = 1; i < PIPE_STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign s1_op   = st[0].op;
    assign s1_addr = st[0].a;
    assign s2_op   = st[1].op;
    assign s2_addr = st[1].a;
    assign s3_op   = st[2].op;
    assign s4_op   = st[3].op;

    // R1: a low read strobe outside the refusal window becomes a read
    a_r1_read_taken: assert property (@(posedge clk) disable iff (rst)
        (!r_n && s1_op != OP_RD) |=> s1_op == OP_RD);

    // R4: two reads never sit in adjacent stages
    a_r4_no_read_pair: assert property (@(posedge clk) disable iff (rst)
        !(s1_op == OP_RD && s2_op == OP_RD));

endmodule

// File: rtl/b4_burst_array.sv
module b4_burst_array
    import burst4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [HALVES-1:0]            half_we,
    input  logic [HALVES-1:0][ADDR_W-1:0] half_addr,
    input  logic [DATA_W-1:0]            d_rise,
    input  logic [DATA_W-1:0]            d_fall,
    input  logic                         snap_en,
    input  logic [ADDR_W-1:0]            snap_addr,
    output logic [BURST-1:0][DATA_W-1:0] snap_q
);
    localparam int ROWS = 1 << ADDR_W;

    logic [BURST-1:0][DATA_W-1:0] mem [ROWS];

    // Each half of a burst lands when its beat pair arrives.
    always_ff @(posedge clk) begin
        for (int h = 0; h < HALVES; h++) begin
            if (half_we[h]) begin
                mem[half_addr[h]][PER_CYCLE*h]   <= d_rise;
                mem[half_addr[h]][PER_CYCLE*h+1] <= d_fall;
            end
        end
    end

    // Snapshot taken after older writes finish, before newer writes land.
    always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (snap_en) snap_q <= mem[snap_addr];
    end

    // R5: both halves never written at the same edge
    a_r5_halves_disjoint: assert property (@(posedge clk) disable iff (rst)
        !(half_we[0] && half_we[HALVES-1]));

endmodule

// File: rtl/b4_read_bus.sv
module b4_read_bus
    import burst4_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         odt_en,
    input  logic                         head_rd,
    input  logic                         tail_rd,
    input  logic [BURST-1:0][DATA_W-1:0] burst,
    output logic [DATA_W-1:0]            q_rise,
    output logic [DATA_W-1:0]            q_fall,
    output logic                         q_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_rise <= '0;
            q_fall <= '0;
            q_oe   <= 1'b0;
        end else if (head_rd) begin
            q_rise <= burst[0];
            q_fall <= burst[1];
            q_oe   <= 1'b1;
        end else if (tail_rd) begin
            q_rise <= burst[PER_CYCLE];
            q_fall <= burst[PER_CYCLE+1];
            q_oe   <= 1'b1;
        end else begin
            q_rise <= '0;
            q_fall <= '0;
            q_oe   <= odt_en;
        end
    end

    // R6: a released bus carries zero data
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !q_oe |-> (q_rise == '0 && q_fall == '0));

    // R6: with termination on, the bus is always driven
    a_r6_odt_driven: assert property (@(posedge clk) disable iff (rst)
        odt_en |=> q_oe);

    // R7: a burst head is followed by its tail without an idle gap
    a_r7_tail_follows: assert property (@(posedge clk) disable iff (rst)
        head_rd |=> q_oe ##1 q_oe);

endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
    import burst4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] d_rise,
    input  logic [DATA_W-1:0] d_fall,
    input  logic              odt_en,
    output logic [DATA_W-1:0] q_rise,
    output logic [DATA_W-1:0] q_fall,
    output logic              q_oe
);
    op_e                          now_op, s1_op, s2_op, s3_op, s4_op;
    logic [ADDR_W-1:0]            s1_addr, s2_addr;
    logic [HALVES-1:0]            half_we;
    logic [HALVES-1:0][ADDR_W-1:0] half_addr;
    logic [BURST-1:0][DATA_W-1:0] snap_q;

    b4_cmd_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk(clk), .rst(rst), .r_n(rd_n), .w_n(wr_n), .addr(cmd_addr),
        .now_op(now_op), .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_op(s2_op), .s2_addr(s2_addr), .s3_op(s3_op), .s4_op(s4_op)
    );

    assign half_we   = {s2_op == OP_WR, s1_op == OP_WR};
    assign half_addr = {s2_addr, s1_addr};

    b4_burst_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst(rst), .half_we(half_we), .half_addr(half_addr),
        .d_rise(d_rise), .d_fall(d_fall),
        .snap_en(s2_op == OP_RD), .snap_addr(s2_addr), .snap_q(snap_q)
    );

    b4_read_bus #(.DATA_W(DATA_W)) u_qbus (
        .clk(clk), .rst(rst), .odt_en(odt_en),
        .head_rd(s3_op == OP_RD), .tail_rd(s4_op == OP_RD), .burst(snap_q),
        .q_rise(q_rise), .q_fall(q_fall), .q_oe(q_oe)
    );

    // R3: an accepted read drives the bus from the third edge after it
    a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
        (now_op == OP_RD) |=> ##3 q_oe);

endmodule

// File: tb/tb_burst4_sram.sv
`timescale 1ns/1ps
module tb_burst4_sram;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NA = 1 << AW;

    logic clk = 0, rst = 1, rd_n = 1, wr_n = 1, odt_en = 1;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] d_rise = '0, d_fall = '0;
    logic [DW-1:0] q_rise, q_fall;
    logic q_oe;

    always #2 clk = ~clk;

    burst4_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .cmd_addr(cmd_addr), .rd_n(rd_n), .wr_n(wr_n),
        .d_rise(d_rise), .d_fall(d_fall), .odt_en(odt_en),
        .q_rise(q_rise), .q_fall(q_fall), .q_oe(q_oe)
    );

    int n_cmp = 0, n_bad = 0;
    logic [DW-1:0] model [NA][4];
    logic [2*DW:0] exp_q [$];
    string tag_q [$];
    bit active = 0, armed = 0, release_rst = 0;
    int prev = 0;                       // 0 no-op, 1 read, 2 write
    logic [DW-1:0] tail0, tail1;
    logic [DW-1:0] pw1 [4], pw2 [4];
    bit pw1_v = 0, pw2_v = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected bus value per cycle.
    initial forever begin
        @(negedge clk);
        if (active) begin
            if (exp_q.size() == 0) check(0, "R3", "scoreboard empty", 0, 1);
            else begin
                logic [2*DW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({q_oe, q_rise, q_fall} == e, t, "read bus {oe,rise,fall}",
                      int'({q_oe, q_rise, q_fall}), int'(e));
            end
        end
    end

    // Driver: drives one command and pushes the bus value due three edges later.
    task automatic issue(bit rn, bit wn, int a, string tag);
        int eff;
        @(posedge clk); #1;
        if (release_rst) begin rst = 0; release_rst = 0; end
        if (armed) active = 1;
        if (pw1_v)      begin d_rise = pw1[0]; d_fall = pw1[1]; end
        else if (pw2_v) begin d_rise = pw2[2]; d_fall = pw2[3]; end
        else            begin d_rise = DW'($urandom); d_fall = DW'($urandom); end
        pw2 = pw1; pw2_v = pw1_v; pw1_v = 0;
        rd_n = rn; wr_n = wn; cmd_addr = a[AW-1:0];
        eff = 0;
        if (!rn && prev != 1)      eff = 1;
        else if (!wn && prev != 2) eff = 2;
        if (eff == 1) begin
            exp_q.push_back({1'b1, model[a][0], model[a][1]});
            tag_q.push_back(tag);
            tail0 = model[a][2]; tail1 = model[a][3];
        end else if (prev == 1) begin
            exp_q.push_back({1'b1, tail0, tail1});
            tag_q.push_back(!rn ? "R4" : "R7");
        end else begin
            exp_q.push_back({odt_en, {DW{1'b0}}, {DW{1'b0}}});
            tag_q.push_back("R6");
        end
        if (eff == 2) begin
            for (int k = 0; k < 4; k++) model[a][k] = DW'($urandom);
            pw1 = model[a]; pw1_v = 1;
        end
        prev = eff;
        armed = 1;
    endtask

    task automatic start_phase(bit odt);
        rst = 1; odt_en = odt; rd_n = 1; wr_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(q_oe == 1'b0, "R9", "q_oe in reset", int'(q_oe), 0);
        check(q_rise == '0 && q_fall == '0, "R9", "data in reset",
              int'({q_rise, q_fall}), 0);
        prev = 0; pw1_v = 0; pw2_v = 0;
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back({odt, {DW{1'b0}}, {DW{1'b0}}});
            tag_q.push_back("R9");
        end
        release_rst = 1;
    endtask

    task automatic drain();
        repeat (4) issue(1, 1, 0, "R6");
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
        active = 0; armed = 0;
    endtask

    task automatic patterns();
        issue(1, 0, 2, "R8"); issue(0, 1, 2, "R8");          // write then read, same address
        issue(1, 1, 0, "R6");
        issue(0, 1, 4, "R8"); issue(1, 0, 4, "R8");          // read then write, old data
        issue(1, 1, 0, "R7"); issue(0, 1, 4, "R8");
        issue(1, 1, 0, "R7");
        issue(0, 1, 6, "R3"); issue(0, 1, 9, "R4");          // second read refused
        issue(1, 1, 0, "R7"); issue(0, 1, 9, "R10");
        issue(1, 1, 0, "R6");
        issue(1, 0, 3, "R5"); issue(1, 0, 5, "R5");          // second write refused
        issue(1, 1, 0, "R6"); issue(0, 1, 5, "R5");
        issue(1, 1, 0, "R6");
        issue(0, 0, 7, "R1"); issue(0, 0, 8, "R1");          // read wins, then write
        issue(1, 1, 0, "R6"); issue(0, 1, 8, "R1");
        issue(1, 1, 0, "R6");
        for (int i = 0; i < 300; i++) begin
            int u = int'($urandom % 4);
            issue(u[0], u[1], int'($urandom % NA), "R8");
        end
    endtask

    initial begin
        start_phase(1'b1);
        for (int a = 0; a < NA; a++) begin
            issue(1, 0, a, "R2"); issue(1, 1, 0, "R6");
        end
        for (int a = 0; a < NA; a++) begin
            issue(0, 1, a, "R2"); issue(1, 1, 0, "R7");
        end
        patterns();
        drain();

        start_phase(1'b0);
        for (int a = 0; a < NA; a++) begin
            issue(0, 1, a, "R9"); issue(1, 1, 0, "R7");
        end
        issue(1, 1, 0, "R6"); issue(1, 0, 11, "R10"); issue(1, 1, 0, "R6");
        for (int a = 0; a < NA; a++) begin
            issue(0, 1, a, "R10"); issue(1, 1, 0, "R7");
        end
        patterns();
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule